// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is an interval timer for a small microcontroller. A 6-bit prescaler divides the system clock. Each time the prescaler finishes a pass, an 8-bit down counter takes one step. When the counter finishes its last step, the block emits a one-cycle interrupt request. Software controls the timer through three byte-wide registers, which are selected by a 2-bit register select:

- a control register, holding a restart strobe and a run enable;
- a count register: a write sets the reload value, and a read returns the live count;
- a write-only scale register, holding the divide factor and the repeat/one-shot choice.

The timer has two modes. In one-shot mode it runs down once and parks at zero. In repeat mode it reloads itself after every expiry and keeps going, which gives a periodic tick of prescale × count clocks. Software reads the live count whenever it likes, and the read does not disturb the count.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, irq is 0 and reads of the control register (select 0) and the count register (select 1) return 0. The timer does not count until its first restart, even when the run enable is set.
- R2: Bits 7:2 of the scale register (select 2) set the divide factor P. The values 1 to 63 divide by that value, and 0 divides by 64.
- R3: Writing the count register sets the reload value C. The values 1 to 255 mean that many steps, and 0 means 256 steps.
- R4: The live count drops by one at the clock edge that completes each pass of P prescaler clocks, and at no other edge.
- R5: After a restart at edge L with the timer enabled, irq is high for exactly one cycle, following edge L+P×C.
- R6: When bit 0 of the scale register is 0 (one-shot), the count stays at 0 after expiry, and no further irq occurs until the next restart.
- R7: When bit 0 of the scale register is 1 (repeat), the counter reloads C at expiry and keeps counting, so irq recurs every P×C cycles.
- R8: Bit 1 of the control register is the run enable. Clearing it freezes both stages. Setting it again resumes from the frozen state.
- R9: Writing 1 to bit 0 of the control register restarts both stages from their reload values at that write's edge, even while the timer is running. This bit always reads back as 0, and bit 1 reads back as the run enable.
- R10: Reading the count, or writing a new reload value, leaves the live count unchanged.
- R11: Reads of the scale register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also feeds the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register selected for a write: 0 control, 1 count, 2 scale |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register selected for a read |
| rd_data | output | 8 | Read data, combinational from rd_sel |
| irq | output | 1 | One-cycle expiry request |

## Verification
The properties assume that every write lasts exactly one cycle, that the select values are 0 to 2, and that reserved bits are written as 0. Under those conditions, the count changes only at a restart or a prescaler pass, and the park-at-zero state holds. The stimulus drives every register access through a single write task and a single read task. Both tasks change inputs only at the falling edge, and they always write 0 to the reserved bits. The scoreboard predicts each irq from the cycle index of the restart edge and P×C, so a missing, early or extra pulse shows up as a mismatch.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_SCALE = 2'd2
  } ptmr_sel_e;

  localparam int CTRL_RESTART_BIT = 0;
  localparam int CTRL_RUN_BIT     = 1;
  localparam int SCALE_REPEAT_BIT = 0;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run_en,
  output logic              restart,
  output logic              repeat_mode,
  output logic [PRE_W-1:0]  pre_init,
  output logic [CNT_W-1:0]  cnt_init
);
  import ptmr_pkg::*;

  logic             run_d, rep_d;
  logic [PRE_W-1:0] pre_d;
  logic [CNT_W-1:0] cnt_d;
  logic             wr_ctrl, wr_count, wr_scale;

  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
  assign wr_count = wr_en && (wr_sel == SEL_COUNT);
  assign wr_scale = wr_en && (wr_sel == SEL_SCALE);
  assign restart  = wr_ctrl && wr_data[CTRL_RESTART_BIT];

  always_comb begin
    run_d = run_en;
    rep_d = repeat_mode;
    pre_d = pre_init;
    cnt_d = cnt_init;
    if (wr_ctrl) run_d = wr_data[CTRL_RUN_BIT];
    if (wr_count) cnt_d = wr_data[CNT_W-1:0];
    if (wr_scale) begin
      pre_d = wr_data[DATA_W-1 -: PRE_W];
      rep_d = wr_data[SCALE_REPEAT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en      <= 1'b0;
      repeat_mode <= 1'b0;
      pre_init    <= '0;
      cnt_init    <= '0;
    end else begin
      run_en      <= run_d;
      repeat_mode <= rep_d;
      pre_init    <= pre_d;
      cnt_init    <= cnt_d;
    end
  end
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic [W-1:0] init,
  output logic         tick
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cur_q, cur_d;

  // A stored 0 decrements through the wrap, giving the full 2**W range.
  assign tick = run && (cur_q == ONE);

  always_comb begin
    cur_d = cur_q;
    if (restart)   cur_d = init;
    else if (tick) cur_d = init;
    else if (run)  cur_d = cur_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  input  logic         repeat_mode,
  input  logic [W-1:0] init,
  output logic [W-1:0] count,
  output logic         parked,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;
  logic         park_d;

  assign expire = step && (count == ONE);

  always_comb begin
    cnt_d  = count;
    park_d = parked;
    if (restart) begin
      cnt_d  = init;
      park_d = 1'b0;
    end else if (expire) begin
      if (repeat_mode) begin
        cnt_d = init;
      end else begin
        cnt_d  = '0;
        park_d = 1'b1;
      end
    end else if (step) begin
      cnt_d = count - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      parked <= 1'b1;
    end else begin
      count  <= cnt_d;
      parked <= park_d;
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import ptmr_pkg::*;

  logic             en_q, load_req, rep_q, pre_tick, cnt_done, expire;
  logic [PRE_W-1:0] pre_init;
  logic [CNT_W-1:0] cnt_init, cnt_cur;
  logic             run;

  ptmr_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .run_en(en_q), .restart(load_req),
    .repeat_mode(rep_q), .pre_init(pre_init), .cnt_init(cnt_init)
  );

  assign run = en_q && !cnt_done;

  ptmr_prescale #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load_req), .run(run),
    .init(pre_init), .tick(pre_tick)
  );

  ptmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(load_req), .step(pre_tick),
    .repeat_mode(rep_q), .init(cnt_init), .count(cnt_cur),
    .parked(cnt_done), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= expire && !load_req;
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL:  rd_data[CTRL_RUN_BIT] = en_q;
      SEL_COUNT: rd_data[CNT_W-1:0] = cnt_cur;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             load_req,
  input logic             pre_tick,
  input logic             cnt_done,
  input logic [CNT_W-1:0] cnt_cur,
  input logic [CNT_W-1:0] cnt_init,
  input logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_PARKED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_done |-> (cnt_cur == '0)); // R6

  AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (cnt_cur == $past(cnt_init)) && !cnt_done); // R9

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load_req) |=> $stable(cnt_cur)); // R8

  AST_STEP_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_tick && !load_req) |=> $stable(cnt_cur)); // R4

  AST_IRQ_FROM_LAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pre_tick && (cnt_cur == ONE))); // R5
endmodule

bind prescaled_timer ptmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .load_req(load_req),
  .pre_tick(pre_tick), .cnt_done(cnt_done), .cnt_cur(cnt_cur),
  .cnt_init(cnt_init), .irq(irq)
);

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int exp_q[$];

  prescaled_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Scoreboard monitor: each irq pulse pops the cycle it was predicted for.
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (exp_q.size() == 0) check("R5 unexpected irq", cyc, -1);
      else check("R5/R7 irq cycle", cyc, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int d);
    rd_sel = s; #1; d = int'(rd_data);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int v, L, L2, D;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values, enable without restart does nothing
    check("R1 irq at reset", int'(irq), 0);
    rd(2'd0, v); check("R1 ctrl read", v, 0);
    rd(2'd1, v); check("R1 count read", v, 0);
    wr(2'd1, 8'd5); wr(2'd0, 8'h02);
    wait_to(cyc + 20);
    rd(2'd1, v); check("R1 no count before restart", v, 0);

    // R2 R3 R4 R6: P=3 C=4 one-shot
    wr(2'd2, 8'h0C); wr(2'd1, 8'd4);
    wr(2'd0, 8'h03); L = cyc; exp_q.push_back(L + 12);
    rd(2'd1, v); check("R3 count after restart", v, 4);
    wait_to(L + 3); rd(2'd1, v); check("R4 first step", v, 3);
    wait_to(L + 30); rd(2'd1, v); check("R6 parked at zero", v, 0);

    // R7 R8: P=2 C=3 repeat, freeze and resume
    wr(2'd2, 8'h09); wr(2'd1, 8'd3);
    wr(2'd0, 8'h03); L = cyc;
    exp_q.push_back(L + 6); exp_q.push_back(L + 12); exp_q.push_back(L + 18);
    wait_to(L + 19); wr(2'd0, 8'h00);
    wait_to(L + 25); rd(2'd1, v); check("R8 frozen count", v, 2);
    wait_to(L + 30); rd(2'd1, v); check("R8 still frozen", v, 2);
    wr(2'd0, 8'h02); D = cyc; exp_q.push_back(D + 4);
    wait_to(D + 4); wr(2'd0, 8'h00);
    wait_to(D + 10); rd(2'd1, v); check("R7 reloaded count", v, 3);
    rd(2'd0, v); check("R8 ctrl shows disabled", v, 0);

    // R2 R3: full range P=64 C=256 one-shot
    wr(2'd2, 8'h00); wr(2'd1, 8'd0);
    wr(2'd0, 8'h03); L = cyc; exp_q.push_back(L + 16384);
    wait_to(L + 63); rd(2'd1, v); check("R2 no step before 64", v, 0);
    wait_to(L + 64); rd(2'd1, v); check("R3 256 steps down to 255", v, 255);
    wait_to(L + 16400); rd(2'd1, v); check("R6 full range parked", v, 0);

    // R7: P=1 C=1 repeat, irq every cycle
    wr(2'd2, 8'h05); wr(2'd1, 8'd1);
    wr(2'd0, 8'h03); L = cyc;
    for (int k = 1; k <= 5; k++) exp_q.push_back(L + k);
    wait_to(L + 4); wr(2'd0, 8'h00);
    wait_to(L + 12);

    // R9 R10: restart while running, reload written mid-run
    wr(2'd2, 8'h10); wr(2'd1, 8'd5);
    wr(2'd0, 8'h03); L = cyc;
    wait_to(L + 7); wr(2'd0, 8'h03); L2 = cyc; exp_q.push_back(L2 + 20);
    rd(2'd1, v); check("R9 restart reloads", v, 5);
    rd(2'd0, v); check("R9 restart bit reads 0", v, 2);
    wait_to(L2 + 5); wr(2'd1, 8'd9);
    rd(2'd1, v); check("R10 reload write keeps count", v, 4);
    rd(2'd1, v); check("R10 repeated read", v, 4);
    rd(2'd2, v); check("R11 scale reads 0", v, 0);
    wait_to(L2 + 30); rd(2'd1, v); check("R6 parked after restart", v, 0);

    check("R5 all predicted irqs seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule